// File: doc/BRIEF.md
# Register-Pointer Two-Wire Slave Front End

This block is the two-wire serial slave side of a peripheral that keeps its state in a bank of 8-bit registers. A host reaches those registers through one stored 8-bit pointer. In a write transaction, the first byte after the address selects the pointer. Every later byte is stored at the pointer, and the pointer then moves on. A read transaction starts sending from wherever the pointer was left. This can be after a write-only pointer setup that ended with STOP. It can also be after a repeated START inside the same bus ownership.

The pointer does not always step by one. Address 0x00 is the window onto an external key FIFO. The pointer holds there, so successive reads drain successive entries, and each byte read from 0x00 pulses `fifo_pop_o`. Address 0x06 steps back to 0x00. Every other address steps by one and wraps modulo 256.

An optional SCL-low watchdog abandons a transaction that stalls. Two write-only bits in the bank produce one-cycle reset strobes for neighbouring logic. SCL and SDA are sampled through two-flop synchronizers. SDA is driven open-drain through `sda_oe_o`.

The controller states are:
- `ST_IDLE`: off the bus.
- `ST_ADDR`: receiving the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_CMD`: receiving the pointer byte.
- `ST_CMD_ACK`: acknowledging the pointer byte.
- `ST_WDATA`: receiving a data byte.
- `ST_WDATA_ACK`: acknowledging a data byte.
- `ST_RDATA`: shifting out a byte.
- `ST_RDATA_ACK`: sampling the master's ACK or NACK.
- `ST_ABORT`: deaf after a timeout.

The transitions are:
- START, from any state, goes to `ST_ADDR`.
- STOP, from any state, goes to `ST_IDLE`.
- A timeout, from any active state, goes to `ST_ABORT`.
- From `ST_ADDR`: a matching address goes to `ST_ADDR_ACK`; a foreign address goes to `ST_IDLE`.
- From `ST_ADDR_ACK`: the read direction goes to `ST_RDATA`; the write direction goes to `ST_CMD`.
- `ST_CMD` goes to `ST_CMD_ACK`, which goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, which goes back to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RDATA_ACK`. On an ACK it returns to `ST_RDATA`; on a NACK it goes to `ST_IDLE`.

Top module: `cmdptr_i2c_slave`

## Requirements
- R1: After reset the slave does not drive SDA and all strobes are low. It acknowledges (SDA low in the ninth clock) an address byte whose upper 7 bits equal `SLV_ADDR` (bit 0 = 1 means read). Any other address is not acknowledged, and the slave ignores the bus until the next START.
- R2: In a write, the first byte after the address is stored as the pointer. A STOP straight after it changes no register.
- R3: In a write, every byte after the pointer byte is acknowledged, stored at the pointer, and followed by a pointer advance.
- R4: A read sends, MSB first, the register at the stored pointer, whether that pointer was set in an earlier transaction or just before a repeated START. The pointer advances after each byte read, by the same rules as for writes.
- R5: Pointer advance rule: 0x00 stays 0x00, 0x06 becomes 0x00, and any other value p becomes (p+1) mod 256. Each byte read at 0x00 returns `fifo_data_i` and pulses `fifo_pop_o` once.
- R6: Reads of addresses outside 0x00, 0x01–0x06 and 0x40–0x5F return 0x00. Writes there, and writes to 0x00, change nothing and pop nothing.
- R7: When the master answers a read byte with NACK (SDA high), the slave releases SDA and stays silent until the next START.
- R8: With bit 0 of register 0x01 set, an SCL-low interval of more than `TMO_MS` ms (counted in `CLK_HZ` cycles) during a transaction abandons it. No acknowledge is given until a new START, and the pointer is unchanged.
- R9: With bit 0 of register 0x01 clear, a long SCL-low interval has no effect on the transaction.
- R10: Writing a byte with bit 7 set to 0x01 pulses `key_rst_o` for one cycle. Bit 7 is not stored (it reads 0); the other bits are.
- R11: Writing a byte with bit 4 set to 0x40 pulses `gpio_rst_o` for one cycle. Bit 4 is not stored (it reads 0); the other bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| fifo_data_i | input | 8 | Head entry of the external key FIFO |
| fifo_pop_o | output | 1 | One-cycle pulse after a byte is read at 0x00 |
| key_rst_o | output | 1 | One-cycle key-switch state reset strobe |
| gpio_rst_o | output | 1 | One-cycle GPIO reset strobe |

## Verification
The embedded properties rely on a bus that obeys the protocol:
- SDA changes only while SCL is low, except when forming a START or STOP.
- Each SCL level lasts several system clocks, so the synchronizers never miss an edge.
- `fifo_data_i` is steady while a byte is being loaded.

The bench drives SCL with a quarter-bit of eight clocks. It moves SDA only in the low phase, and it stretches SCL low beyond the timeout only in the dedicated timeout scenarios. Register contents and FIFO values are predicted by a bench model that applies the advance rule and the bit masks arithmetically.

// File: rtl/cmdptr_pkg.sv
package cmdptr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_ABORT
    } slv_state_e;

    localparam logic [7:0] FIFO_ADDR   = 8'h00;
    localparam logic [7:0] CTL_LO      = 8'h01;
    localparam logic [7:0] CTL_HI      = 8'h06;
    localparam logic [7:0] GP_LO       = 8'h40;
    localparam logic [7:0] GP_HI       = 8'h5F;
    localparam logic [7:0] CFG_ADDR    = 8'h01;
    localparam logic [7:0] GCFG_ADDR   = 8'h40;
    localparam int         KEYRST_BIT  = 7;
    localparam int         GPIORST_BIT = 4;
    localparam int         TMO_EN_BIT  = 0;
    localparam int         CTL_N       = int'(CTL_HI) - int'(CTL_LO) + 1;
    localparam int         GP_N        = int'(GP_HI) - int'(GP_LO) + 1;

    // pointer step: hold on the FIFO window, fold 0x06 back, else +1 mod 256
    function automatic logic [7:0] ptr_advance(input logic [7:0] p);
        if (p == FIFO_ADDR)
            return FIFO_ADDR;
        else if (p == CTL_HI)
            return FIFO_ADDR;
        else
            return p + 8'd1;
    endfunction

endpackage

// File: rtl/cmdptr_line_sync.sv
module cmdptr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/cmdptr_bus_timer.sv
module cmdptr_bus_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic scl_low_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          exp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (!arm_i || !scl_low_i) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                cnt_q <= '0;
                exp_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign expire_o = exp_q;

    // R8
    tmo_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(arm_i) && $past(scl_low_i));

    // R9
    tmo_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> !expire_o);

endmodule

// File: rtl/cmdptr_regbank.sv
module cmdptr_regbank
    import cmdptr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [7:0] rd_addr_i,
    input  logic [7:0] fifo_data_i,
    output logic [7:0] rd_data_o,
    output logic       tmo_en_o,
    output logic       key_rst_o,
    output logic       gpio_rst_o
);
    localparam int CIW = $clog2(CTL_N);
    localparam int GIW = $clog2(GP_N);

    logic [7:0] ctl_q [CTL_N];
    logic [7:0] gp_q  [GP_N];
    logic       key_q, gpio_q;

    logic       wr_ctl, wr_gp, rd_ctl, rd_gp;
    logic [7:0] wr_coff, wr_goff, rd_coff, rd_goff;
    logic [7:0] wr_val;

    assign wr_ctl  = (wr_addr_i >= CTL_LO) && (wr_addr_i <= CTL_HI);
    assign wr_gp   = (wr_addr_i >= GP_LO)  && (wr_addr_i <= GP_HI);
    assign rd_ctl  = (rd_addr_i >= CTL_LO) && (rd_addr_i <= CTL_HI);
    assign rd_gp   = (rd_addr_i >= GP_LO)  && (rd_addr_i <= GP_HI);
    assign wr_coff = wr_addr_i - CTL_LO;
    assign wr_goff = wr_addr_i - GP_LO;
    assign rd_coff = rd_addr_i - CTL_LO;
    assign rd_goff = rd_addr_i - GP_LO;

    // strobe bits are not kept in the array
    always_comb begin
        wr_val = wr_data_i;
        if (wr_addr_i == CFG_ADDR)  wr_val[KEYRST_BIT]  = 1'b0;
        if (wr_addr_i == GCFG_ADDR) wr_val[GPIORST_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CTL_N; i++) ctl_q[i] <= '0;
            for (int j = 0; j < GP_N; j++)  gp_q[j]  <= '0;
            key_q  <= 1'b0;
            gpio_q <= 1'b0;
        end else begin
            key_q  <= wr_en_i && (wr_addr_i == CFG_ADDR)  && wr_data_i[KEYRST_BIT];
            gpio_q <= wr_en_i && (wr_addr_i == GCFG_ADDR) && wr_data_i[GPIORST_BIT];
            if (wr_en_i && wr_ctl) ctl_q[wr_coff[CIW-1:0]] <= wr_val;
            if (wr_en_i && wr_gp)  gp_q[wr_goff[GIW-1:0]]  <= wr_val;
        end
    end

    always_comb begin
        if (rd_addr_i == FIFO_ADDR) rd_data_o = fifo_data_i;
        else if (rd_ctl)            rd_data_o = ctl_q[rd_coff[CIW-1:0]];
        else if (rd_gp)             rd_data_o = gp_q[rd_goff[GIW-1:0]];
        else                        rd_data_o = 8'h00;
    end

    assign tmo_en_o   = ctl_q[0][TMO_EN_BIT];
    assign key_rst_o  = key_q;
    assign gpio_rst_o = gpio_q;

    // R10
    key_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == CFG_ADDR && wr_data_i[KEYRST_BIT]) |=> key_rst_o);

    // R10
    key_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_rst_o |=> !key_rst_o);

    // R11
    gpio_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_rst_o |=> !gpio_rst_o);

    // R6
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i != FIFO_ADDR && !rd_ctl && !rd_gp) |-> rd_data_o == 8'h00);

endmodule

// File: rtl/cmdptr_i2c_slave.sv
module cmdptr_i2c_slave
    import cmdptr_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h38,
    parameter int         CLK_HZ   = 50_000_000,
    parameter int         TMO_MS   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [7:0] fifo_data_i,
    output logic       fifo_pop_o,
    output logic       key_rst_o,
    output logic       gpio_rst_o
);
    localparam int TMO_CYC = (CLK_HZ / 1000) * TMO_MS;

    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    slv_state_e state_q, state_d;
    logic [2:0] bitcnt_q, bitcnt_d;
    logic       full_q, full_d;
    logic [7:0] sh_q, sh_d;
    logic [7:0] ptr_q, ptr_d;
    logic       rw_q, rw_d;
    logic       nack_q, nack_d;
    logic       sda_oe_q, sda_oe_d;
    logic       pop_q, pop_c;
    logic       wr_en_c;
    logic [7:0] rd_data;
    logic       tmo_en, tmo_arm, tmo_hit;

    cmdptr_line_sync #(.STAGES(2)) scl_sync_i (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .lvl_o(scl_s), .prev_o(scl_p));
    cmdptr_line_sync #(.STAGES(2)) sda_sync_i (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .lvl_o(sda_s), .prev_o(sda_p));

    assign scl_rise = scl_s && !scl_p;
    assign scl_fall = !scl_s && scl_p;
    assign start_ev = scl_s && scl_p && sda_p && !sda_s;
    assign stop_ev  = scl_s && scl_p && !sda_p && sda_s;

    assign tmo_arm = tmo_en && (state_q != ST_IDLE) && (state_q != ST_ABORT);

    cmdptr_bus_timer #(.LIMIT(TMO_CYC)) timer_i (
        .clk(clk), .rst_n(rst_n), .arm_i(tmo_arm), .scl_low_i(!scl_s),
        .expire_o(tmo_hit));

    cmdptr_regbank bank_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_c), .wr_addr_i(ptr_q), .wr_data_i(sh_q),
        .rd_addr_i(ptr_q), .fifo_data_i(fifo_data_i), .rd_data_o(rd_data),
        .tmo_en_o(tmo_en), .key_rst_o(key_rst_o), .gpio_rst_o(gpio_rst_o));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            full_q   <= 1'b0;
            sh_q     <= '0;
            ptr_q    <= '0;
            rw_q     <= 1'b0;
            nack_q   <= 1'b0;
            sda_oe_q <= 1'b0;
            pop_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            bitcnt_q <= bitcnt_d;
            full_q   <= full_d;
            sh_q     <= sh_d;
            ptr_q    <= ptr_d;
            rw_q     <= rw_d;
            nack_q   <= nack_d;
            sda_oe_q <= sda_oe_d;
            pop_q    <= pop_c;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        bitcnt_d = bitcnt_q;
        full_d   = full_q;
        sh_d     = sh_q;
        ptr_d    = ptr_q;
        rw_d     = rw_q;
        nack_d   = nack_q;
        wr_en_c  = 1'b0;
        pop_c    = 1'b0;
        if (start_ev) begin
            state_d  = ST_ADDR;
            bitcnt_d = '0;
            full_d   = 1'b0;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (tmo_hit) begin
            state_d = ST_ABORT;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_ABORT: ;
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise) begin
                        sh_d     = {sh_q[6:0], sda_s};
                        bitcnt_d = bitcnt_q + 3'd1;
                        if (bitcnt_q == 3'd7) full_d = 1'b1;
                    end else if (scl_fall && full_q) begin
                        full_d   = 1'b0;
                        bitcnt_d = '0;
                        if (state_q == ST_ADDR) begin
                            if (sh_q[7:1] == SLV_ADDR) begin
                                rw_d    = sh_q[0];
                                state_d = ST_ADDR_ACK;
                            end else begin
                                state_d = ST_IDLE;
                            end
                        end else if (state_q == ST_CMD) begin
                            ptr_d   = sh_q;
                            state_d = ST_CMD_ACK;
                        end else begin
                            wr_en_c = 1'b1;
                            ptr_d   = ptr_advance(ptr_q);
                            state_d = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            state_d  = ST_RDATA;
                            sh_d     = rd_data;
                            bitcnt_d = '0;
                        end else begin
                            state_d = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) state_d = ST_WDATA;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bitcnt_q == 3'd7) begin
                            state_d = ST_RDATA_ACK;
                            pop_c   = (ptr_q == FIFO_ADDR);
                            ptr_d   = ptr_advance(ptr_q);
                        end else begin
                            sh_d     = {sh_q[6:0], 1'b0};
                            bitcnt_d = bitcnt_q + 3'd1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        nack_d = sda_s;
                    end else if (scl_fall) begin
                        if (nack_q) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d  = ST_RDATA;
                            sh_d     = rd_data;
                            bitcnt_d = '0;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_d)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe_d = 1'b1;
            ST_RDATA:                              sda_oe_d = !sh_d[7];
            default:                               sda_oe_d = 1'b0;
        endcase
    end

    assign sda_oe_o   = sda_oe_q;
    assign fifo_pop_o = pop_q;

    // R1
    addr_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && scl_fall && full_q && sh_q[7:1] != SLV_ADDR &&
         !start_ev && !stop_ev && !tmo_hit) |=> !sda_oe_o);

    // R5
    ptr_fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_c && ptr_q == FIFO_ADDR) |=> ptr_q == FIFO_ADDR);

    // R5
    ptr_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_c && ptr_q == CTL_HI) |=> ptr_q == FIFO_ADDR);

    // R7
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA_ACK && nack_q && scl_fall &&
         !start_ev && !stop_ev && !tmo_hit) |=> (state_q == ST_IDLE) && !sda_oe_o);

    // R8
    tmo_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_hit && !start_ev && !stop_ev) |=> state_q == ST_ABORT && !sda_oe_o);

    // R8
    abort_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT && !start_ev) |=> !sda_oe_o && $stable(ptr_q));

endmodule

// File: tb/cmdptr_i2c_slave_tb.sv
module cmdptr_i2c_slave_tb_top;
    localparam int CLK_PER = 10;
    localparam int Q       = 8;
    localparam int TMO_CYC = 400;
    localparam logic [6:0] ADDR = 7'h38;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, fifo_pop, key_rst, gpio_rst;
    logic sda_line;
    logic [7:0] fifo_data;
    int   pop_cnt = 0, key_cnt = 0, gpio_cnt = 0;
    int   n_chk = 0, n_fail = 0;
    logic [7:0] mdl [256];
    logic [7:0] m_ptr = 8'h00;
    int   exp_pops = 0, exp_key = 0, exp_gpio = 0;

    always #(CLK_PER/2) clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign fifo_data = 8'(8'h80 + pop_cnt);

    cmdptr_i2c_slave #(.SLV_ADDR(ADDR), .CLK_HZ(20_000), .TMO_MS(20)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .fifo_data_i(fifo_data), .fifo_pop_o(fifo_pop),
        .key_rst_o(key_rst), .gpio_rst_o(gpio_rst));

    always @(posedge clk) begin
        if (fifo_pop) pop_cnt <= pop_cnt + 1;
        if (key_rst)  key_cnt <= key_cnt + 1;
        if (gpio_rst) gpio_cnt <= gpio_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    function automatic logic [7:0] adv(input logic [7:0] p);
        if (p == 8'h00 || p == 8'h06) return 8'h00;
        return 8'(p + 1);
    endfunction

    function automatic logic [7:0] mdl_rd(input logic [7:0] p);
        if ((p >= 8'h01 && p <= 8'h06) || (p >= 8'h40 && p <= 8'h5F)) return mdl[p];
        return 8'h00;
    endfunction

    task automatic mdl_wr(input logic [7:0] p, input logic [7:0] d);
        if (p >= 8'h01 && p <= 8'h06) begin
            mdl[p] = (p == 8'h01) ? (d & 8'h7F) : d;
            if (p == 8'h01 && d[7]) exp_key++;
        end else if (p >= 8'h40 && p <= 8'h5F) begin
            mdl[p] = (p == 8'h40) ? (d & 8'hEF) : d;
            if (p == 8'h40 && d[4]) exp_gpio++;
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq();
        m_sda = 1'b0; waitq(); m_scl = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; waitq(); m_scl = 1'b1; waitq();
        m_sda = 1'b1; waitq(); waitq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nak);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; waitq(); m_scl = 1'b1; waitq(); waitq();
            m_scl = 1'b0; waitq();
        end
        m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq();
        nak = sda_line; waitq(); m_scl = 1'b0; waitq();
    endtask

    task automatic recv_byte(input logic nak, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitq(); m_scl = 1'b1; waitq();
            b[i] = sda_line; waitq(); m_scl = 1'b0; waitq();
        end
        m_sda = nak; waitq(); m_scl = 1'b1; waitq(); waitq();
        m_scl = 1'b0; waitq(); m_sda = 1'b1;
    endtask

    task automatic read_bytes(input int n, input string tag);
        logic [7:0] b, e;
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            if (m_ptr == 8'h00) begin
                e = 8'(8'h80 + exp_pops);
                exp_pops++;
            end else begin
                e = mdl_rd(m_ptr);
            end
            chk(tag, b, e);
            m_ptr = adv(m_ptr);
        end
    endtask

    task automatic wr_txn(input logic [7:0] p, input int n, input int seed, input string tag);
        logic nak;
        logic [7:0] d;
        bus_start();
        send_byte({ADDR, 1'b0}, nak); chk({tag, " R1 addr ack"}, nak, 0);
        send_byte(p, nak);            chk({tag, " R2 cmd ack"}, nak, 0);
        m_ptr = p;
        for (int i = 0; i < n; i++) begin
            d = 8'((seed + i * 37) ^ 8'h5A);
            send_byte(d, nak); chk({tag, " R3 data ack"}, nak, 0);
            mdl_wr(m_ptr, d);
            m_ptr = adv(m_ptr);
        end
        bus_stop();
    endtask

    task automatic rs_read(input logic [7:0] p, input int n, input string tag);
        logic nak;
        bus_start();
        send_byte({ADDR, 1'b0}, nak); chk({tag, " R1 ack"}, nak, 0);
        send_byte(p, nak);            chk({tag, " R2 cmd ack"}, nak, 0);
        m_ptr = p;
        bus_start();
        send_byte({ADDR, 1'b1}, nak); chk({tag, " R4 rs addr ack"}, nak, 0);
        read_bytes(n, tag);
        bus_stop();
    endtask

    task automatic plain_read(input int n, input string tag);
        logic nak;
        bus_start();
        send_byte({ADDR, 1'b1}, nak); chk({tag, " R4 addr ack"}, nak, 0);
        read_bytes(n, tag);
        bus_stop();
    endtask

    task automatic one_write(input logic [7:0] p, input logic [7:0] d);
        logic nak;
        bus_start();
        send_byte({ADDR, 1'b0}, nak);
        send_byte(p, nak);
        send_byte(d, nak);
        mdl_wr(p, d);
        m_ptr = adv(p);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (190_000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic nak;
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R1 reset key strobe", key_rst, 0);
        chk("R1 reset gpio strobe", gpio_rst, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 foreign address
        bus_start();
        send_byte({7'h22, 1'b0}, nak); chk("R1 foreign addr nack", nak, 1);
        send_byte(8'h41, nak);         chk("R1 ignored after foreign", nak, 1);
        bus_stop();

        // R3 R5 sweeps: general bank, control bank folding to FIFO window
        wr_txn(8'h40, 32, 3, "R3 gp sweep");
        wr_txn(8'h01, 8, 200, "R3 ctl sweep");
        chk("R6 fifo write no pop", pop_cnt, 0);
        rs_read(8'h40, 32, "R4 gp readback");
        rs_read(8'h01, 9, "R5 ctl fold fifo");
        chk("R5 pop count", pop_cnt, exp_pops);

        // R2 pointer-only setup then separate read
        bus_start();
        send_byte({ADDR, 1'b0}, nak);
        send_byte(8'h43, nak); chk("R2 cmd ack", nak, 0);
        bus_stop();
        m_ptr = 8'h43;
        plain_read(3, "R2 R4 ptr kept");

        // R6 unmapped and wrap modulo 256
        one_write(8'h20, 8'h55);
        rs_read(8'hFE, 4, "R5 R6 wrap");
        rs_read(8'h20, 1, "R6 unmapped read");
        chk("R5 pop count 2", pop_cnt, exp_pops);

        // R10 R11 strobes
        one_write(8'h01, 8'h82);
        chk("R10 key pulses", key_cnt, exp_key);
        rs_read(8'h01, 1, "R10 bit7 not stored");
        one_write(8'h40, 8'h1F);
        chk("R11 gpio pulses", gpio_cnt, exp_gpio);
        rs_read(8'h40, 1, "R11 bit4 not stored");

        // R7 release after NACK
        rs_read(8'h03, 2, "R7 read");
        repeat (20) @(negedge clk);
        chk("R7 sda released", sda_oe, 0);

        // R9 timeout disabled (0x01 bit0 = 0)
        one_write(8'h01, 8'h00);
        bus_start();
        send_byte({ADDR, 1'b0}, nak);
        repeat (3 * TMO_CYC) @(negedge clk);
        send_byte(8'h05, nak); chk("R9 no abort when off", nak, 0);
        bus_stop();
        m_ptr = 8'h05;
        plain_read(1, "R9 ptr set");

        // R8 timeout enabled
        one_write(8'h01, 8'h01);
        bus_start();
        send_byte({ADDR, 1'b0}, nak);
        repeat (2 * TMO_CYC) @(negedge clk);
        chk("R8 sda released", sda_oe, 0);
        send_byte(8'h05, nak); chk("R8 abort nack", nak, 1);
        send_byte(8'h33, nak); chk("R8 still deaf", nak, 1);
        bus_stop();
        plain_read(1, "R8 ptr unchanged");
        rs_read(8'h02, 2, "R8 recovered");

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule